// File: doc/BRIEF.md
# Cascadable Display Driver Serial Load Front End

This block is the serial loading stage of a dot-matrix display driver designed to be chained with others of its kind. One serial data line feeds either a long dot shift register (the pixel pattern) or a short 8-bit control shift register. A select line chooses between the two. When the chip-enable strobe ends, the selected shift register is copied into its holding register. A control byte whose top bit is set carries two mode fields. The first is a data-out routing flag. The second is a divide-by-8 enable for an external display oscillator. A control byte whose top bit is clear is passed on as a brightness word, which this block does not decode.

Drivers are chained by wiring the data output of each one to the data input of the next. In serial routing mode, a control byte travels down the chain 8 bits per driver, so N drivers need 8·N clocks. In simultaneous routing mode, the data output mirrors the data input during control writes. Every driver then sees the same byte at the same time, and the whole chain is loaded in 8 clocks. Dot writes always shift through the full chain, so the second driver's bit 0 becomes chain position 160.

All logic runs on one system clock. Serial bits arrive as a valid/ready stream. `din_ready` is high exactly while `ce_n` is low, which is the write window. A bit is taken on each rising clock edge where both `din_valid` and `din_ready` are high. When `din_valid` is low, no bit is taken and the shift registers hold. The sender must hold `din` and `din_valid` until the bit is taken. Back-pressure is applied only outside the write window, so a sender that drops `ce_n` can stream one bit per cycle.

Top module: `ddrv_serial_front`

## Requirements
- R1: After `rst_n` is released, `sim_mode`, `ext_div8`, `proto_err`, `bright_word` and every bit of `dot_image` are 0.
- R2: `din_ready` equals the inverse of `ce_n`. Each handshake shifts `din` into bit 0 of the register selected by `rs`, and earlier bits move one place up. Bits are therefore sent most significant first.
- R3: On the first clock edge where `ce_n` is seen high after being low, with `rs` = 1, the control shift register is latched. If the latched byte has bit 7 = 1, it is control word 1. If it has bit 7 = 0, its bits 6..0 go to `bright_word` and the control word 1 fields are left unchanged.
- R4: In control word 1, bit 0 is stored as `sim_mode` (0 = serial, 1 = simultaneous) and bit 1 is stored as `ext_div8`. A control word 0 leaves both unchanged.
- R5: When `rs` = 1 and `sim_mode` = 0, `dout` is bit 7 of the control shift register.
- R6: When `rs` = 1 and `sim_mode` = 1, `dout` follows `din` combinationally, with no clock delay.
- R7: When `rs` = 0, `dout` is bit 159 (the last bit) of the dot shift register in both routing modes.
- R8: `proto_err` is the OR of bits 6..2 of the most recent control word 1. A control word 0 does not change it.
- R9: On the end of a write window with `rs` = 0, `dot_image` takes the dot shift register. `dot_image[0]` holds the most recently shifted bit.
- R10: With two drivers chained (`dout` to `din`), a control byte reaches both in 8 handshakes when both are in simultaneous mode, and needs 16 handshakes in serial mode. A 320-bit dot stream puts its first bit at the second driver's bit 159.
- R11: A cycle with `din_valid` = 0 during a write window takes no bit, whatever the value of `din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Write window, active low; its rising end latches |
| rs | input | 1 | Register select: 1 = control, 0 = dot |
| din_valid | input | 1 | Serial bit valid |
| din_ready | output | 1 | Serial bit accepted when high together with valid |
| din | input | 1 | Serial data bit |
| dout | output | 1 | Chain output to the next driver |
| sim_mode | output | 1 | Control word 1 routing flag |
| ext_div8 | output | 1 | Control word 1 external oscillator divide-by-8 enable |
| proto_err | output | 1 | Reserved bits of last control word 1 were non-zero |
| bright_word | output | 7 | Bits 6..0 of the last control word 0 |
| dot_image | output | 160 | Latched dot pattern |

## Verification
The hardest state to reach from the ports is a chain of two drivers whose routing flags disagree with the data that is passing through them. Putting both drivers into simultaneous mode takes a 16-bit serial frame. After that, one 8-bit frame must reach both drivers, and a following 8-bit serial frame must leave the second driver holding the first driver's previous byte. The bench drives exactly this sequence on two chained instances. It also sweeps all 256 control bytes through one driver, checking `dout` against the previous byte or against `din` at every shift.

// File: rtl/ddrv_pkg.sv
package ddrv_pkg;
  localparam int CTRL_BITS   = 8;
  localparam int SEL_BIT     = 7;
  localparam int SIM_BIT     = 0;
  localparam int DIV_BIT     = 1;
  localparam int RSV_LO      = 2;
  localparam int RSV_HI      = 6;
  localparam int BRIGHT_BITS = 7;

  typedef struct packed {
    logic div8;
    logic simul;
  } cw1_fields_t;
endpackage

// File: rtl/ddrv_shift_reg.sv
module ddrv_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  generate
    if (W == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {q[W-2:0], din};
      end
    end
  endgenerate

  // R2: a taken bit lands in position 0
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> q[0] == $past(din));
  // R11: no handshake, no movement
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(q));
endmodule

// File: rtl/ddrv_ctrl_decode.sv
module ddrv_ctrl_decode
  import ddrv_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   latch_en,
  input  logic [CTRL_BITS-1:0]   word,
  output cw1_fields_t            fields,
  output logic                   proto_err,
  output logic [BRIGHT_BITS-1:0] bright
);
  logic is_cw1;
  assign is_cw1 = word[SEL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields    <= '0;
      proto_err <= 1'b0;
      bright    <= '0;
    end else if (latch_en) begin
      if (is_cw1) begin
        fields.simul <= word[SIM_BIT];
        fields.div8  <= word[DIV_BIT];
        proto_err    <= |word[RSV_HI:RSV_LO];
      end else begin
        bright <= word[BRIGHT_BITS-1:0];
      end
    end
  end

  // R3 / R4: control word 0 never touches the word-1 fields
  p_cw0_keeps_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && !word[SEL_BIT]) |=> ($stable(fields) && $stable(proto_err)));
  // R8: error flag reflects reserved bits of the latched word 1
  p_err_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && word[SEL_BIT]) |=> proto_err == (|$past(word[RSV_HI:RSV_LO])));
  // R3: nothing changes between latch events
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> ($stable(fields) && $stable(bright)));
endmodule

// File: rtl/ddrv_dout_mux.sv
module ddrv_dout_mux (
  input  logic rs,
  input  logic simul,
  input  logic din,
  input  logic ctrl_msb,
  input  logic dot_msb,
  output logic dout
);
  always_comb begin
    if (rs) dout = simul ? din : ctrl_msb;
    else    dout = dot_msb;
  end
endmodule

// File: rtl/ddrv_serial_front.sv
module ddrv_serial_front
  import ddrv_pkg::*;
#(
  parameter int DOT_BITS = 160
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_n,
  input  logic                   rs,
  input  logic                   din_valid,
  output logic                   din_ready,
  input  logic                   din,
  output logic                   dout,
  output logic                   sim_mode,
  output logic                   ext_div8,
  output logic                   proto_err,
  output logic [BRIGHT_BITS-1:0] bright_word,
  output logic [DOT_BITS-1:0]    dot_image
);
  localparam int DOT_MSB = DOT_BITS - 1;

  logic                 ce_q;
  logic                 take;
  logic                 ctrl_shift;
  logic                 dot_shift;
  logic                 window_end;
  logic                 ctrl_latch;
  logic                 dot_latch;
  logic [CTRL_BITS-1:0] ctrl_q;
  logic [DOT_BITS-1:0]  dot_q;
  cw1_fields_t          fields;

  assign din_ready  = ~ce_n;
  assign take       = din_valid & din_ready;
  assign ctrl_shift = take & rs;
  assign dot_shift  = take & ~rs;
  assign window_end = ce_n & ~ce_q;
  assign ctrl_latch = window_end & rs;
  assign dot_latch  = window_end & ~rs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_q <= 1'b1;
    else        ce_q <= ce_n;
  end

  ddrv_shift_reg #(.W(CTRL_BITS)) u_ctrl_sr (
    .clk(clk), .rst_n(rst_n), .shift_en(ctrl_shift), .din(din), .q(ctrl_q)
  );

  ddrv_shift_reg #(.W(DOT_BITS)) u_dot_sr (
    .clk(clk), .rst_n(rst_n), .shift_en(dot_shift), .din(din), .q(dot_q)
  );

  ddrv_ctrl_decode u_decode (
    .clk(clk), .rst_n(rst_n), .latch_en(ctrl_latch), .word(ctrl_q),
    .fields(fields), .proto_err(proto_err), .bright(bright_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dot_image <= '0;
    else if (dot_latch) dot_image <= dot_q;
  end

  ddrv_dout_mux u_mux (
    .rs(rs), .simul(fields.simul), .din(din),
    .ctrl_msb(ctrl_q[CTRL_BITS-1]), .dot_msb(dot_q[DOT_MSB]), .dout(dout)
  );

  assign sim_mode = fields.simul;
  assign ext_div8 = fields.div8;

  // R9: the dot image only moves at the end of a write window
  p_image_only_on_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |=> $stable(dot_image));
  // R6: simultaneous routing passes the input straight through
  p_sim_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs && sim_mode) |-> dout == din);
  // R2: no bits are taken outside the write window
  p_no_take_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> ($stable(ctrl_q) && $stable(dot_q)));
endmodule

// File: tb/ddrv_serial_front_bench.sv
module ddrv_serial_front_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, rs = 1'b0, din_valid = 1'b0, din = 1'b0;
  logic rdy_a, rdy_b, dout_a, dout_b;
  logic sim_a, sim_b, div_a, div_b, err_a, err_b;
  logic [6:0] br_a, br_b;
  logic [159:0] img_a, img_b;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  ddrv_serial_front u_ddrv_serial_front (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rs(rs), .din_valid(din_valid),
    .din_ready(rdy_a), .din(din), .dout(dout_a), .sim_mode(sim_a),
    .ext_div8(div_a), .proto_err(err_a), .bright_word(br_a), .dot_image(img_a)
  );

  ddrv_serial_front u_ddrv_serial_front_b (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rs(rs), .din_valid(din_valid),
    .din_ready(rdy_b), .din(dout_a), .dout(dout_b), .sim_mode(sim_b),
    .ext_div8(div_b), .proto_err(err_b), .bright_word(br_b), .dot_image(img_b)
  );

  function automatic logic pat(input int k);
    return logic'(((k * 5 + (k >> 3)) ^ (k >> 1)) & 1);
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode 0: control byte repeated, 1: dot pattern. dchk: 0 none, 1 serial prev, 2 sim, 3 dot
  task automatic frame(input logic r, input int n, input int mode, input logic [7:0] w,
                       input int dchk, input logic [7:0] prev, input logic gaps);
    @(negedge clk);
    ce_n = 1'b0; rs = r;
    for (int k = 0; k < n; k++) begin
      logic b;
      b = (mode == 0) ? w[7 - (k % 8)] : pat(k);
      if (gaps) begin
        @(negedge clk);
        din_valid = 1'b0; din = ~b;
        @(negedge clk);
      end else begin
        @(negedge clk);
      end
      din = b; din_valid = 1'b1;
      #1;
      if (dchk == 1 && k < 8)
        check(dout_a == prev[7 - k], "R5 serial dout", 32'(dout_a), 32'(prev[7 - k]));
      if (dchk == 2)
        check(dout_a == din, "R6 sim dout", 32'(dout_a), 32'(din));
      if (dchk == 3)
        check(dout_a == ((k >= 160) ? pat(k - 160) : 1'b0), "R7 dot dout",
              32'(dout_a), 32'((k >= 160) ? pat(k - 160) : 1'b0));
    end
    @(negedge clk);
    din_valid = 1'b0; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic e_sim, e_div, e_err;
    logic [6:0] e_br;
    logic [7:0] prev;
    logic ok;
    do_reset();
    // R1 reset state
    check(!sim_a && !div_a && !err_a, "R1 fields", 32'({sim_a, div_a, err_a}), 0);
    check(br_a == 0 && img_a == '0, "R1 bright/image", 32'(br_a), 0);
    // R2 ready follows the window
    check(rdy_a == 1'b0, "R2 ready idle", 32'(rdy_a), 0);
    ce_n = 1'b0; #1;
    check(rdy_a == 1'b1, "R2 ready window", 32'(rdy_a), 1);
    ce_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 R6 R8: sweep of all control bytes
    e_sim = 0; e_div = 0; e_err = 0; e_br = 0; prev = 8'h00;
    for (int w = 0; w < 256; w++) begin
      logic [7:0] wb;
      wb = 8'(w);
      frame(1'b1, 8, 0, wb, e_sim ? 2 : 1, prev, 1'b0);
      if (wb[7]) begin
        e_sim = wb[0]; e_div = wb[1]; e_err = |wb[6:2];
      end else begin
        e_br = wb[6:0];
      end
      ok = (sim_a == e_sim) && (div_a == e_div) && (err_a == e_err) && (br_a == e_br);
      check(ok, "R3 R4 R8 decode", {21'd0, sim_a, div_a, err_a, 1'b0, br_a},
            {21'd0, e_sim, e_div, e_err, 1'b0, e_br});
      prev = wb;
    end

    // R11: idle cycles with toggling din take no bit
    frame(1'b1, 8, 0, 8'h82, 0, 8'h00, 1'b1);
    check(sim_a == 0 && div_a == 1 && err_a == 0, "R11 gaps ignored",
          32'({sim_a, div_a, err_a}), 32'(3'b010));
    frame(1'b1, 8, 0, 8'h20, 0, 8'h00, 1'b1);
    check(br_a == 7'h20 && div_a == 1, "R11 cw0 with gaps", 32'(br_a), 32'h20);

    // R7 R9: dot stream in simultaneous mode still leaves from bit 159
    frame(1'b1, 8, 0, 8'h81, 0, 8'h00, 1'b0);
    check(sim_a == 1, "R4 sim set", 32'(sim_a), 1);
    frame(1'b0, 200, 1, 8'h00, 3, 8'h00, 1'b0);
    ok = 1'b1;
    for (int i = 0; i < 160; i++) if (img_a[i] != pat(199 - i)) ok = 1'b0;
    check(ok, "R9 dot image", 32'(img_a[31:0]), 0);
    check(sim_a == 1 && br_a == 7'h20, "R9 dot write keeps control", 32'(sim_a), 1);

    // R10: chained pair
    do_reset();
    frame(1'b1, 16, 0, 8'h81, 0, 8'h00, 1'b0);
    check(sim_a && sim_b, "R10 serial 16 clocks", 32'({sim_a, sim_b}), 3);
    frame(1'b1, 8, 0, 8'h82, 0, 8'h00, 1'b0);
    check(!sim_a && !sim_b && div_a && div_b, "R10 sim 8 clocks",
          32'({sim_a, sim_b, div_a, div_b}), 32'(4'b0011));
    frame(1'b1, 8, 0, 8'h80, 0, 8'h00, 1'b0);
    check(!div_a && div_b && !sim_b, "R10 serial 8 clocks reach one",
          32'({div_a, div_b}), 32'(2'b01));
    frame(1'b0, 320, 1, 8'h00, 0, 8'h00, 1'b0);
    ok = 1'b1;
    for (int i = 0; i < 160; i++) begin
      if (img_a[i] != pat(319 - i)) ok = 1'b0;
      if (img_b[i] != pat(159 - i)) ok = 1'b0;
    end
    check(ok, "R10 320-bit chain", 32'(img_b[31:0]), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule